// File: doc/BRIEF.md
# Half-Duplex Serial Register Read Master

This block is the host side of a two-line serial link: one clock line and one shared data line. It reads 8-bit registers from a peripheral. A read begins with a one-cycle start request and a 7-bit register address on a parallel interface. The block then runs a frame of sixteen serial clocks. In the first eight clocks it drives a read-direction bit followed by the address. It then releases the data line and holds the clock high through a turnaround interval, which gives the peripheral time to prepare its reply. In the last eight clocks it clocks the reply byte in. The byte is returned on a parallel output together with a one-cycle completion strobe.

The serial clock is derived from the system clock. Its half-period and the turnaround interval are both parameters counted in system-clock cycles. The data line is presented as a separate output value and output enable, and the pad logic outside the block combines them. A power-down input blocks new frames from starting.

Top module: `sio_rd_master`

## Requirements
- R1: After reset, and whenever no frame is running, `sclk` is 1, `sdio_oe` is 0, `rd_done` is 0 and `busy` is 0. Out of reset, `rd_data` is 0.
- R2: Across the first eight rising edges of `sclk` in a frame, the bits on `sdio_out` are 0 (the read marker) and then address bits 6 down to 0. `sdio_oe` is 1 at each of these edges.
- R3: Every low phase of `sclk` in a frame lasts exactly HALF_CYC system cycles. Every high phase other than the one after the eighth rising edge also lasts HALF_CYC cycles. This includes the high phase after the sixteenth rising edge, which `rd_done` closes.
- R4: While the master drives the line, `sdio_out` changes only in the cycle in which `sclk` falls.
- R5: `sdio_oe` falls exactly HALF_CYC cycles after the eighth rising edge and stays 0 for the rest of the frame.
- R6: The ninth falling edge of `sclk` comes exactly TURN_CYC system cycles after the eighth rising edge (TURN_CYC > HALF_CYC).
- R7: `sdio_in` is sampled at rising edges 9 to 16, most significant bit first, and the assembled byte appears on `rd_data`.
- R8: `rd_done` is high for exactly one cycle per frame. `rd_data` changes only in that cycle.
- R9: A start request made while `busy` is 1 is ignored. It does not change the frame in progress and does not cause a further frame.
- R10: A start request made while `pwr_down` is 1 is ignored. No clock edge occurs and `busy` stays 0.
- R11: `busy` rises in the cycle after an accepted start and stays 1 until the cycle in which `rd_done` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down | input | 1 | Blocks acceptance of new frames while high |
| rd_start | input | 1 | Request to begin a read frame |
| rd_addr | input | 7 | Register address, captured when the start is accepted |
| rd_data | output | 8 | Byte from the last completed frame |
| rd_done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | A frame is in progress |
| sclk | output | 1 | Serial clock, idles high |
| sdio_out | output | 1 | Data line value driven by the master |
| sdio_oe | output | 1 | Data line driver enable |
| sdio_in | input | 1 | Data line value seen from the pad |

## Verification
The bench builds the block with HALF_CYC = 2 and TURN_CYC = 7. A whole frame therefore takes under a hundred cycles, which makes it cheap to sweep every one of the 128 addresses, each with its own arithmetic reply byte, plus all-zero and all-one replies at the end addresses. A small turnaround that is still longer than the half-period keeps the release point and the first data edge apart. Each phase length, the release cycle and the turnaround can then be measured cycle by cycle against the two parameters.

// File: rtl/sio_rd_pkg.sv
package sio_rd_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int BIT_IDX_W = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_TURN = 2'd2,
    ST_DATA = 2'd3
  } rd_state_t;

  // Header byte shifted out first: read marker (0) followed by the address.
  function automatic logic [BYTE_W-1:0] header_byte(input logic [ADDR_W-1:0] a);
    return {1'b0, a};
  endfunction

  // True when the bit index points at the final bit of a byte.
  function automatic logic is_last_bit(input logic [BIT_IDX_W-1:0] idx);
    return idx == BIT_IDX_W'(BYTE_W - 1);
  endfunction

  // Next shift-register value: drop the msb, append the incoming bit.
  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur,
                                                 input logic bit_in);
    return {cur[BYTE_W-2:0], bit_in};
  endfunction

endpackage

// File: rtl/sio_rd_halfgen.sv
module sio_rd_halfgen #(
  parameter int HALF_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = !clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sio_rd_turnwait.sv
module sio_rd_turnwait #(
  parameter int HALF_CYC = 24,
  parameter int TURN_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic drv_release,
  output logic expire
);

  localparam int CW = $clog2(TURN_CYC + 1);
  localparam logic [CW-1:0] REL_AT = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] EXP_AT = CW'(TURN_CYC - 1);

  logic [CW-1:0] cnt;

  assign drv_release = run && (cnt == REL_AT);
  assign expire      = run && (cnt == EXP_AT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (!expire) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sio_rd_shreg.sv
module sio_rd_shreg
  import sio_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              shift_en,
  input  logic              ser_in,
  output logic [BYTE_W-1:0] q,
  output logic              msb
);

  assign msb = q[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (shift_en) begin
      q <= shift_in(q, ser_in);
    end
  end

endmodule

// File: rtl/sio_rd_master.sv
module sio_rd_master
  import sio_rd_pkg::*;
#(
  parameter int HALF_CYC = 24,
  parameter int TURN_CYC = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_done,
  output logic              busy,
  output logic              sclk,
  output logic              sdio_out,
  output logic              sdio_oe,
  input  logic              sdio_in
);

  generate
    if (TURN_CYC <= HALF_CYC || HALF_CYC < 1) begin : g_bad_cfg
      $error("sio_rd_master: need TURN_CYC > HALF_CYC >= 1");
    end
  endgenerate

  rd_state_t st;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic sclk_q;
  logic oe_q;

  // Named internal events (also observed by the checker).
  logic accept;
  logic in_addr_ph, in_turn_ph, in_data_ph;
  logic half_tick, rise_ev, fall_ev, last_bit;
  logic addr_end, frame_end;
  logic turn_release, turn_expire;
  logic sr_load, sr_shift, sr_ser;
  logic [BYTE_W-1:0] sr_q;
  logic sr_msb;

  assign in_addr_ph = (st == ST_ADDR);
  assign in_turn_ph = (st == ST_TURN);
  assign in_data_ph = (st == ST_DATA);
  assign accept     = rd_start && (st == ST_IDLE) && !pwr_down;

  assign last_bit  = is_last_bit(bit_idx);
  assign rise_ev   = half_tick && !sclk_q;
  assign fall_ev   = half_tick && sclk_q && !last_bit;
  assign addr_end  = in_addr_ph && rise_ev && last_bit;
  assign frame_end = in_data_ph && half_tick && sclk_q && last_bit;

  assign sr_load  = accept;
  assign sr_shift = (in_addr_ph && fall_ev) || (in_data_ph && rise_ev);
  assign sr_ser   = in_data_ph ? sdio_in : 1'b0;

  sio_rd_halfgen #(
    .HALF_CYC(HALF_CYC)
  ) u_half (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!(in_addr_ph || in_data_ph)),
    .tick (half_tick)
  );

  sio_rd_turnwait #(
    .HALF_CYC(HALF_CYC),
    .TURN_CYC(TURN_CYC)
  ) u_turn (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (in_turn_ph),
    .drv_release(turn_release),
    .expire     (turn_expire)
  );

  sio_rd_shreg u_sr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (sr_load),
    .load_val(header_byte(rd_addr)),
    .shift_en(sr_shift),
    .ser_in  (sr_ser),
    .q       (sr_q),
    .msb     (sr_msb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_idx <= '0;
      sclk_q  <= 1'b1;
      oe_q    <= 1'b0;
      rd_done <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            st      <= ST_ADDR;
            sclk_q  <= 1'b0;
            oe_q    <= 1'b1;
            bit_idx <= '0;
          end
        end
        ST_ADDR: begin
          if (rise_ev) begin
            sclk_q <= 1'b1;
            if (last_bit) st <= ST_TURN;
          end else if (fall_ev) begin
            sclk_q  <= 1'b0;
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_TURN: begin
          if (turn_release) oe_q <= 1'b0;
          if (turn_expire) begin
            st      <= ST_DATA;
            sclk_q  <= 1'b0;
            bit_idx <= '0;
          end
        end
        ST_DATA: begin
          if (rise_ev) begin
            sclk_q <= 1'b1;
          end else if (frame_end) begin
            st      <= ST_IDLE;
            rd_done <= 1'b1;
            rd_data <= sr_q;
          end else if (fall_ev) begin
            sclk_q  <= 1'b0;
            bit_idx <= bit_idx + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sclk     = sclk_q;
  assign sdio_oe  = oe_q;
  assign sdio_out = oe_q & sr_msb;
  assign busy     = (st != ST_IDLE);

endmodule

// File: rtl/sio_rd_checker.sv
module sio_rd_checker #(
  parameter int HALF_CYC = 24,
  parameter int TURN_CYC = 20000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_down,
  input logic       rd_start,
  input logic [7:0] rd_data,
  input logic       rd_done,
  input logic       busy,
  input logic       sclk,
  input logic       sdio_out,
  input logic       sdio_oe,
  input logic       in_data_ph
);

  localparam int CW = $clog2(TURN_CYC + 2) + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      if (!sclk) hi_cnt <= '0;
      else if (hi_cnt != CMAX) hi_cnt <= hi_cnt + 1'b1;
      if (sclk) lo_cnt <= '0;
      else if (lo_cnt != CMAX) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk && !sdio_oe)); // R1

  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe && $past(sdio_oe) && !$fell(sclk)) |-> $stable(sdio_out)); // R4

  AST_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(sclk)) |-> (lo_cnt == CW'(HALF_CYC))); // R3

  AST_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $fell(sclk)) |->
      (hi_cnt == CW'(HALF_CYC) || hi_cnt == CW'(TURN_CYC))); // R6

  AST_RELEASED_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    in_data_ph |-> !sdio_oe); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done); // R8

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |-> $stable(rd_data)); // R8

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(rd_start) && !$past(pwr_down))); // R11

  AST_PD_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && !busy) |=> !busy); // R10

endmodule

bind sio_rd_master sio_rd_checker #(
  .HALF_CYC(HALF_CYC),
  .TURN_CYC(TURN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_down  (pwr_down),
  .rd_start  (rd_start),
  .rd_data   (rd_data),
  .rd_done   (rd_done),
  .busy      (busy),
  .sclk      (sclk),
  .sdio_out  (sdio_out),
  .sdio_oe   (sdio_oe),
  .in_data_ph(in_data_ph)
);

// File: tb/sio_rd_master_tb.sv
`timescale 1ns/1ps
module sio_rd_master_tb;

  localparam int HALF = 2;
  localparam int TURN = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_down = 1'b0;
  logic       rd_start = 1'b0;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rd_done;
  logic       busy;
  logic       sclk;
  logic       sdio_out;
  logic       sdio_oe;
  logic       sdio_in = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sio_rd_master #(
    .HALF_CYC(HALF),
    .TURN_CYC(TURN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
    .rd_start(rd_start), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_done(rd_done), .busy(busy),
    .sclk(sclk), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
    .sdio_in(sdio_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reply_of(input logic [6:0] a);
    return 8'((int'(a) * 53 + 19) % 256) ^ {a[0], 7'b0};
  endfunction

  // Runs one frame acting as the peripheral; samples at negative clock edges.
  task automatic read_frame(input logic [6:0] a, input logic [7:0] d, input bit inject);
    int cyc = 0, last_t = 0, rises = 0, falls = 0;
    int r8_t = -1000, rel_t = -2000, turn_dt = -1, done_dt = -1;
    int phase_err = 0, oe_err = 0, edge_err = 0, busy_err = 0;
    logic prev_s = 1'b1, prev_oe = 1'b0, prev_out = 1'b0;
    logic [7:0] got = '0;
    bit done_seen = 0;
    @(negedge clk);
    rd_start = 1'b1;
    rd_addr  = a;
    @(negedge clk);
    rd_start = 1'b0;
    rd_addr  = ~a;
    while (!done_seen && cyc < 2000) begin
      if (sclk != prev_s) begin
        int dt = cyc - last_t;
        last_t = cyc;
        if (!sclk) begin
          falls++;
          if (falls == 9) turn_dt = dt;
          else if (falls > 1 && dt != HALF) phase_err++;
          if (falls <= 8 && !sdio_oe) oe_err++;
          if (falls >= 9) begin
            if (sdio_oe) oe_err++;
            sdio_in = d[7 - (falls - 9)];
          end
        end else begin
          rises++;
          if (dt != HALF) phase_err++;
          if (rises <= 8) begin
            got = {got[6:0], sdio_out};
            if (!sdio_oe) oe_err++;
          end
          if (rises == 8) r8_t = cyc;
        end
      end else if (sdio_oe && prev_oe && sdio_out != prev_out) begin
        edge_err++;
      end
      if (prev_oe && !sdio_oe) rel_t = cyc;
      if (rises > 8 && sdio_oe) oe_err++;
      if (rd_done) begin
        done_seen = 1;
        done_dt = cyc - last_t;
      end else if (!busy) begin
        busy_err++;
      end
      rd_start = inject && (falls == 3);
      rd_addr  = inject ? (a ^ 7'h55) : ~a;
      prev_s = sclk; prev_oe = sdio_oe; prev_out = sdio_out;
      @(negedge clk);
      cyc++;
    end
    rd_start = 1'b0;
    chk(done_seen, "R8 done seen", int'(done_seen), 1);
    chk(got == {1'b0, a}, "R2 header bits", int'(got), int'({1'b0, a}));
    chk(phase_err == 0 && done_dt == HALF, "R3 phase lengths", done_dt + 100 * phase_err, HALF);
    chk(edge_err == 0, "R4 drive only on falling edge", edge_err, 0);
    chk(rel_t - r8_t == HALF && oe_err == 0, "R5 release point", rel_t - r8_t + 100 * oe_err, HALF);
    chk(turn_dt == TURN, "R6 turnaround", turn_dt, TURN);
    chk(rises == 16 && rd_data == d, "R7 returned byte", int'(rd_data), int'(d));
    chk(busy_err == 0, "R11 busy during frame", busy_err, 0);
    chk(rd_done == 1'b0 && rd_data == d, "R8 single strobe, held data", int'(rd_done), 0);
    if (inject) begin
      int extra = 0;
      repeat (4 * HALF + TURN) begin
        @(negedge clk);
        if (busy || !sclk || sdio_oe) extra++;
      end
      chk(extra == 0, "R9 start while busy ignored", extra, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int lines_bad;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(sclk && !sdio_oe && !rd_done && !busy && rd_data == 8'h00, "R1 reset state",
        int'({sclk, sdio_oe, rd_done, busy}), 8);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sclk && !sdio_oe && !busy, "R1 idle after reset", int'({sclk, sdio_oe, busy}), 4);

    for (int i = 0; i < 128; i++) begin
      read_frame(7'(i), reply_of(7'(i)), (i % 16) == 5);
    end
    read_frame(7'h00, 8'hFF, 1'b0);
    read_frame(7'h7F, 8'h00, 1'b0);
    read_frame(7'h2A, 8'hA5, 1'b1);

    // R10: start under power-down is ignored
    @(negedge clk);
    pwr_down = 1'b1;
    rd_start = 1'b1;
    rd_addr  = 7'h33;
    @(negedge clk);
    rd_start = 1'b0;
    lines_bad = 0;
    repeat (3 * TURN) begin
      @(negedge clk);
      if (busy || !sclk || sdio_oe || rd_done) lines_bad++;
    end
    chk(lines_bad == 0, "R10 power-down blocks start", lines_bad, 0);
    chk(rd_data == 8'hA5, "R8 data held across idle", int'(rd_data), 8'hA5);
    pwr_down = 1'b0;
    read_frame(7'h33, reply_of(7'h33), 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule